// File: doc/BRIEF.md
# Line Transceiver Direction Controller

This block sits beside a UART and decides, on every clock, whether the external line driver and the line receiver are switched on. It supports a full-duplex four-wire connection and three half-duplex two-wire arrangements. In the half-duplex arrangements the driver is keyed either by the modem-control DTR output or automatically by pending transmit data. A master gate turns both directions off while the port is idle or shut down. A separate bit switches on the bus termination network.

Software controls the block through two 8-bit registers on a simple register bus that has an offset, a write strobe and combinational read data. The wiring-control register holds the wire mode, the master gate and the termination bit. The auxiliary register holds an auto-DTR bit. When that bit is set, the block generates DTR itself from transmitter activity instead of passing the UART's own DTR through. All enable outputs are registered, so they change only at clock edges and cannot glitch.

Top module: `xcvr_dir_ctrl`

## Requirements
- R1: After reset, the wiring-control register reads 0x03 (automatic mode, gate off, termination off). The auxiliary register reads 0x00. `drv_en`, `rcv_en`, `term_en` and `dtr_line` are all 0.
- R2: The wiring-control register sits at offset 0xF. Bits [1:0] (wire mode), 3 (master gate) and 6 (termination) read back as last written. Bits 2, 4, 5 and 7 always read 0, and writes to them are ignored.
- R3: The auxiliary register sits at offset 0x2. Only bit 4 (auto-DTR) is stored and read back, and every other bit reads 0. Any other offset reads 0x00, and a write to it changes neither register.
- R4: While the master gate (bit 3) is 0, `drv_en` and `rcv_en` are both 0 in every wire mode.
- R5: In wire mode 0 (full duplex) with the gate set, `drv_en` and `rcv_en` are both 1.
- R6: In wire mode 1 (half duplex with echo) with the gate set, `drv_en` follows the effective DTR and `rcv_en` is 1.
- R7: In wire mode 2 (DTR-keyed half duplex) with the gate set, `drv_en` follows the effective DTR and `rcv_en` is its inverse.
- R8: In wire mode 3 (automatic) with the gate set, `drv_en` is 1 while `txf_nonempty` or `tx_busy` is 1. This keeps the driver on until the last stop bit has left the shifter. `rcv_en` is the inverse of `drv_en`.
- R9: `term_en` equals bit 6 of the wiring-control register, whatever the gate and the mode.
- R10: The effective DTR is `txf_nonempty | tx_busy` when auto-DTR is set, and `dtr_in` otherwise. It is presented on `dtr_line` and keys modes 1 and 2.
- R11: `drv_en`, `rcv_en` and `dtr_line` reflect the inputs and the register contents sampled at the preceding rising edge. A register write therefore affects them one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (4) | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| dtr_in | input | 1 | DTR modem-control output of the UART |
| txf_nonempty | input | 1 | Transmit FIFO holds at least one character |
| tx_busy | input | 1 | Transmit shifter active, through the stop bit |
| drv_en | output | 1 | Line driver enable |
| rcv_en | output | 1 | Line receiver enable |
| term_en | output | 1 | Bus termination enable |
| dtr_line | output | 1 | Effective DTR (generated or passed through) |

## Verification
The assertions assume that `dtr_in`, `txf_nonempty`, `tx_busy` and the register bus inputs are synchronous to `clk` and settle before each rising edge. They also assume that `tx_busy` already covers the stop bit, so the block adds no delay of its own. The stimulus changes every input only on the falling edge and holds `reg_we` for exactly one cycle per write. It draws the status inputs at random, including cycles where the FIFO has drained but the shifter is still busy. This keeps the behaviour inside those assumptions while still reaching every mode and gate combination.

// File: rtl/xdc_pkg.sv
// Shared definitions for the transceiver direction controller.
// Assumes 8-bit registers; bit positions are fixed by software convention.
package xdc_pkg;

    typedef enum logic [1:0] {
        WM_FULL = 2'd0,   // four-wire, both directions always on
        WM_ECHO = 2'd1,   // two-wire, driver keyed by DTR, receiver always on
        WM_DTR  = 2'd2,   // two-wire, driver keyed by DTR, receiver off while driving
        WM_AUTO = 2'd3    // two-wire, driver keyed by transmit activity
    } wire_mode_e;

    localparam int unsigned REG_W      = 8;
    localparam int unsigned GATE_BIT   = 3;
    localparam int unsigned TERM_BIT   = 6;
    localparam int unsigned ADTR_BIT   = 4;

    localparam wire_mode_e  MODE_RESET = WM_AUTO;

endpackage

// File: rtl/xdc_ctrl_regs.sv
// Register file of the direction controller: the wiring-control register
// and the auxiliary register holding auto-DTR. Only implemented bits are
// stored; reserved bits read 0. Read data is combinational from the offset.
module xdc_ctrl_regs
    import xdc_pkg::*;
#(
    parameter int unsigned          ADDR_W  = 4,
    parameter logic [ADDR_W-1:0]    WCR_OFS = 4'hF,
    parameter logic [ADDR_W-1:0]    AUX_OFS = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    output wire_mode_e        mode_q,
    output logic              gate_q,
    output logic              term_q,
    output logic              adtr_q
);

    logic wcr_sel;
    logic aux_sel;

    assign wcr_sel = (addr == WCR_OFS);
    assign aux_sel = (addr == AUX_OFS);

    // Store the wiring-control fields on a write to its offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RESET;
            gate_q <= 1'b0;
            term_q <= 1'b0;
        end else if (we && wcr_sel) begin
            mode_q <= wire_mode_e'(wdata[1:0]);
            gate_q <= wdata[GATE_BIT];
            term_q <= wdata[TERM_BIT];
        end
    end

    // Store the auto-DTR bit on a write to the auxiliary offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            adtr_q <= 1'b0;
        else if (we && aux_sel)
            adtr_q <= wdata[ADTR_BIT];
    end

    // Assemble read data; reserved bits and unmapped offsets return zero.
    always_comb begin
        rdata = '0;
        if (wcr_sel) begin
            rdata[1:0]      = mode_q;
            rdata[GATE_BIT] = gate_q;
            rdata[TERM_BIT] = term_q;
        end else if (aux_sel) begin
            rdata[ADTR_BIT] = adtr_q;
        end
    end

endmodule

// File: rtl/xdc_dir_logic.sv
// Direction decision: from the wire mode, the master gate and the UART
// status, computes driver and receiver enables and the effective DTR.
// Assumes tx_busy stays high through the stop bit of the last character.
// All outputs are registered so the transceiver sees clean edges.
module xdc_dir_logic
    import xdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  wire_mode_e mode,
    input  logic       gate,
    input  logic       adtr,
    input  logic       dtr_in,
    input  logic       txf_nonempty,
    input  logic       tx_busy,
    output logic       drv_en,
    output logic       rcv_en,
    output logic       dtr_line
);

    logic tx_active;
    logic dtr_eff;
    logic drv_next;
    logic rcv_next;

    // Transmit activity spans queued data and the shifter, stop bit included.
    assign tx_active = txf_nonempty | tx_busy;
    assign dtr_eff   = adtr ? tx_active : dtr_in;

    // Per-mode enable rules, then the master gate.
    always_comb begin
        unique case (mode)
            WM_FULL: begin drv_next = 1'b1;      rcv_next = 1'b1;      end
            WM_ECHO: begin drv_next = dtr_eff;   rcv_next = 1'b1;      end
            WM_DTR:  begin drv_next = dtr_eff;   rcv_next = !dtr_eff;  end
            default: begin drv_next = tx_active; rcv_next = !tx_active; end
        endcase
        if (!gate) begin
            drv_next = 1'b0;
            rcv_next = 1'b0;
        end
    end

    // Register the enables and the effective DTR.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            drv_en   <= 1'b0;
            rcv_en   <= 1'b0;
            dtr_line <= 1'b0;
        end else begin
            drv_en   <= drv_next;
            rcv_en   <= rcv_next;
            dtr_line <= dtr_eff;
        end
    end

endmodule

// File: rtl/xcvr_dir_ctrl.sv
// Top of the transceiver direction controller: register file plus the
// registered direction decision. Termination follows its register bit.
module xcvr_dir_ctrl
    import xdc_pkg::*;
#(
    parameter int unsigned          ADDR_W  = 4,
    parameter logic [ADDR_W-1:0]    WCR_OFS = 4'hF,
    parameter logic [ADDR_W-1:0]    AUX_OFS = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              dtr_in,
    input  logic              txf_nonempty,
    input  logic              tx_busy,
    output logic              drv_en,
    output logic              rcv_en,
    output logic              term_en,
    output logic              dtr_line
);

    wire_mode_e mode_q;
    logic       gate_q;
    logic       term_q;
    logic       adtr_q;

    xdc_ctrl_regs #(
        .ADDR_W  (ADDR_W),
        .WCR_OFS (WCR_OFS),
        .AUX_OFS (AUX_OFS)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .mode_q (mode_q),
        .gate_q (gate_q),
        .term_q (term_q),
        .adtr_q (adtr_q)
    );

    xdc_dir_logic dir_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode         (mode_q),
        .gate         (gate_q),
        .adtr         (adtr_q),
        .dtr_in       (dtr_in),
        .txf_nonempty (txf_nonempty),
        .tx_busy      (tx_busy),
        .drv_en       (drv_en),
        .rcv_en       (rcv_en),
        .dtr_line     (dtr_line)
    );

    assign term_en = term_q;

endmodule

// File: rtl/xdc_checker.sv
// Property checker for the direction controller, bound into the top.
module xdc_checker
    import xdc_pkg::*;
#(
    parameter int unsigned       ADDR_W  = 4,
    parameter logic [ADDR_W-1:0] WCR_OFS = 4'hF
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input wire_mode_e        mode_q,
    input logic              gate_q,
    input logic              adtr_q,
    input logic              txf_nonempty,
    input logic              tx_busy,
    input logic              drv_en,
    input logic              rcv_en,
    input logic              dtr_line
);

    // R2: reserved bits of the wiring-control register never read as 1
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == WCR_OFS) |-> ((reg_rdata & 8'hB4) == 8'h00));

    // R4: a cleared gate forces both directions off on the next cycle
    a_r4_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
        !gate_q |=> (!drv_en && !rcv_en));

    // R5: full duplex keeps both directions on
    a_r5_full_duplex: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && mode_q == WM_FULL) |=> (drv_en && rcv_en));

    // R7: in DTR-keyed mode the receiver never listens while driving
    a_r7_no_listen_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && mode_q == WM_DTR) |=> (drv_en != rcv_en));

    // R8: automatic mode holds the driver while data or a stop bit remains
    a_r8_auto_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_q && mode_q == WM_AUTO && (txf_nonempty || tx_busy)) |=> (drv_en && !rcv_en));

    // R10: auto-DTR generates DTR from transmit activity
    a_r10_auto_dtr: assert property (@(posedge clk) disable iff (!rst_n)
        (adtr_q && !txf_nonempty && !tx_busy) |=> !dtr_line);

endmodule

bind xcvr_dir_ctrl xdc_checker #(
    .ADDR_W  (ADDR_W),
    .WCR_OFS (WCR_OFS)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .mode_q       (mode_q),
    .gate_q       (gate_q),
    .adtr_q       (adtr_q),
    .txf_nonempty (txf_nonempty),
    .tx_busy      (tx_busy),
    .drv_en       (drv_en),
    .rcv_en       (rcv_en),
    .dtr_line     (dtr_line)
);

// File: tb/xcvr_dir_ctrl_tb_top.sv
// Bench: behavioural reference model updated on every rising edge and
// compared with the outputs 1 ns later on every cycle.
module xcvr_dir_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [3:0] reg_addr = 4'hF;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       dtr_in = 1'b0;
    logic       txf_nonempty = 1'b0;
    logic       tx_busy = 1'b0;
    logic       drv_en, rcv_en, term_en, dtr_line;

    always #2 clk = ~clk;  // 250 MHz

    xcvr_dir_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dtr_in(dtr_in),
        .txf_nonempty(txf_nonempty), .tx_busy(tx_busy), .drv_en(drv_en),
        .rcv_en(rcv_en), .term_en(term_en), .dtr_line(dtr_line)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string tag = "R1";

    // Reference state
    int m_wcr = 0;
    int m_aux = 0;
    int e_drv = 0, e_rcv = 0, e_dtr = 0;

    // Model: applies the requirement rules at each rising edge.
    always @(posedge clk) begin
        int act, dtre, md, d, r;
        if (!rst_n) begin
            m_wcr = 'h03; m_aux = 0; e_drv = 0; e_rcv = 0; e_dtr = 0;
        end else begin
            act  = (txf_nonempty || tx_busy) ? 1 : 0;
            dtre = ((m_aux & 'h10) != 0) ? act : int'(dtr_in);
            md   = m_wcr & 3;
            if (md == 0)      begin d = 1;    r = 1;    end
            else if (md == 1) begin d = dtre; r = 1;    end
            else if (md == 2) begin d = dtre; r = 1 - d; end
            else              begin d = act;  r = 1 - d; end
            if ((m_wcr & 'h08) == 0) begin d = 0; r = 0; end
            e_drv = d; e_rcv = r; e_dtr = dtre;
            if (reg_we && reg_addr == 4'hF) m_wcr = int'(reg_wdata) & 'h4B;
            if (reg_we && reg_addr == 4'h2) m_aux = int'(reg_wdata) & 'h10;
        end
    end

    // Compare one nanosecond after each rising edge.
    always begin
        int exp_rd;
        @(posedge clk);
        #1;
        if (chk_on) begin
            exp_rd = (reg_addr == 4'hF) ? m_wcr : (reg_addr == 4'h2) ? m_aux : 0;
            n_cmp++;
            if (drv_en !== e_drv[0] || rcv_en !== e_rcv[0] || dtr_line !== e_dtr[0] ||
                term_en !== ((m_wcr & 'h40) != 0) || reg_rdata !== exp_rd[7:0]) begin
                n_bad++;
                $display("FAIL %s: drv/rcv/dtr/term/rd = %0b%0b%0b%0b/%02h expected %0b%0b%0b%0b/%02h",
                         tag, drv_en, rcv_en, dtr_line, term_en, reg_rdata,
                         e_drv[0], e_rcv[0], e_dtr[0], (m_wcr & 'h40) != 0, exp_rd[7:0]);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            dtr_in       = 1'($urandom);
            txf_nonempty = 1'($urandom);
            tx_busy      = 1'($urandom);
            reg_addr     = (i % 3 == 0) ? 4'h2 : 4'hF;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk_on = 1'b1;                 // R1: reset values compared during reset
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        reg_addr = 4'h2;
        repeat (2) @(negedge clk);
        reg_addr = 4'hF;
        repeat (2) @(negedge clk);

        tag = "R2";                    // reserved bits of wiring register
        wr(4'hF, 8'hFF); @(negedge clk);
        wr(4'hF, 8'hB4); @(negedge clk);

        tag = "R3";                    // aux register and unmapped offsets
        wr(4'h2, 8'hFF); reg_addr = 4'h2; @(negedge clk);
        wr(4'h5, 8'hFF); reg_addr = 4'h5; @(negedge clk);
        reg_addr = 4'hF; @(negedge clk);
        wr(4'h2, 8'h00);

        tag = "R4";                    // gate off in every mode
        for (int m = 0; m < 4; m++) begin
            wr(4'hF, 8'(m));
            rand_run(12);
        end

        tag = "R5"; wr(4'hF, 8'h08); rand_run(20);
        tag = "R6"; wr(4'hF, 8'h09); rand_run(30);
        tag = "R7"; wr(4'hF, 8'h0A); rand_run(30);

        tag = "R8"; wr(4'hF, 8'h0B);   // drain: FIFO empties, shifter still busy
        @(negedge clk); dtr_in = 1'b1; txf_nonempty = 1'b1; tx_busy = 1'b0;
        @(negedge clk); txf_nonempty = 1'b1; tx_busy = 1'b1;
        @(negedge clk); txf_nonempty = 1'b0; tx_busy = 1'b1;
        @(negedge clk); tx_busy = 1'b1;
        @(negedge clk); tx_busy = 1'b0;
        @(negedge clk);
        rand_run(30);

        tag = "R9";                    // termination independent of gate
        wr(4'hF, 8'h40); rand_run(4);
        wr(4'hF, 8'h4A); rand_run(4);
        wr(4'hF, 8'h0A); rand_run(4);

        tag = "R10"; wr(4'h2, 8'h10);
        wr(4'hF, 8'h09); rand_run(25);
        wr(4'hF, 8'h0A); rand_run(25);
        wr(4'hF, 8'h0B); rand_run(10);
        wr(4'h2, 8'h00); rand_run(10);

        tag = "R11";                   // one-cycle latency after mode switches
        for (int k = 0; k < 8; k++) begin
            wr(4'hF, 8'(8 + (k % 4)));
            rand_run(3);
        end

        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: cycles 100000 expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule